// File: doc/BRIEF.md
# PCI Target Address-Phase Decoder

This block watches the shared PCI address/data bus for the start of a transaction. The start is the first clock at which FRAME# is sampled low after being high. In that clock it captures the 32-bit address and the four-bit bus command. On the next clock it captures the parity bit that covers them. It then decides whether this target takes the transaction. It also reports which kind of command was issued and, for memory commands, how the low two address bits order the burst.

The target's memory window is given by a base and a mask. An address hits when every bit selected by the mask matches the base. In positive mode a memory command that hits is claimed. In subtractive mode the block leaves every transaction alone for a short while and takes a memory command only if no other agent has claimed it by then. Reserved burst-ordering codes on a claimed memory access raise a request to disconnect after the first data phase. Reserved command codes are decoded as reserved and are never claimed.

Top module: `pci_addr_decode`

## Requirements
- R1: The command class output is set one clock after the address phase and holds until the next address phase. Its codes are: 0110→1 (memory read), 0111→2 (memory write), 1100→3 (read multiple), 1110→4 (read line), 1111→5 (write and invalidate), 0010→6 (I/O read), 0011→7 (I/O write), 1010→8 (config read), 1011→9 (config write), 0000→10, 0001→11, 1101→12. The reserved commands 0100, 0101, 1000 and 1001 map to 15.
- R2: For the five memory commands the burst output reads address bits [1:0]. 00 gives 1 (linear) and 10 gives 2 (cache wrap).
- R3: For a memory command, address bits [1:0] of 01 or 11 give burst code 3. When such an access is claimed, the disconnect request pulses in the same cycle as the claim.
- R4: For every command that is not a memory command, the burst output is 0 and no disconnect is requested, whatever address bits [1:0] hold.
- R5: With subtractive mode off, the block claims a memory command when (address & mask) == (base & mask). The claim pulse lasts one cycle and comes one clock after the address phase. A miss gives no claim.
- R6: Reserved commands are never claimed, even when the address hits the window.
- R7: One clock after the address phase, the block checks the XOR of the address, the command and PAR. If that XOR is odd, the parity-error flag pulses for one cycle. Address bits [1:0] are part of this check.
- R8: With subtractive mode on, there is no claim one clock after the address phase. A memory command is claimed three clocks after the address phase if the other-agent claim input was low at each of those three edges.
- R9: In subtractive mode, the other-agent claim input seen high at any of those three edges cancels the claim.
- R10: After reset, the claim, disconnect and parity-error outputs are 0, the class is 0 and the burst code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction framing, active low |
| ad | input | 32 | Address/data bus |
| cbe | input | 4 | Command / byte enables |
| par | input | 1 | Even parity over ad and cbe, valid one clock after the address |
| win_base | input | 32 | Memory window base |
| win_mask | input | 32 | Memory window compare mask |
| sub_mode | input | 1 | Subtractive decoding enable |
| other_claim | input | 1 | Another agent has claimed the transaction |
| claim_o | output | 1 | One-cycle claim strobe |
| cls_o | output | 4 | Decoded command class |
| burst_o | output | 2 | Burst-order code |
| disc_o | output | 1 | Disconnect-after-first-data-phase request |
| perr_o | output | 1 | Address parity error pulse |

## Verification
Call the clock edge that captures the address edge A. The class, burst code, positive claim, disconnect request and parity flag all become visible after edge A+1. A subtractive claim becomes visible only after edge A+3. Every bench task drives its inputs on falling edges and reads the outputs on the falling edge that follows the edge where each result is due. For the subtractive cases the bench also checks the intermediate falling edges, so a claim that comes too early is caught as well as one that is missing.

// File: rtl/pad_pkg.sv
package pad_pkg;
  typedef enum logic [3:0] {
    CLS_NONE       = 4'd0,
    CLS_MEM_RD     = 4'd1,
    CLS_MEM_WR     = 4'd2,
    CLS_MEM_RDMULT = 4'd3,
    CLS_MEM_RDLINE = 4'd4,
    CLS_MEM_WRINV  = 4'd5,
    CLS_IO_RD      = 4'd6,
    CLS_IO_WR      = 4'd7,
    CLS_CFG_RD     = 4'd8,
    CLS_CFG_WR     = 4'd9,
    CLS_INT_ACK    = 4'd10,
    CLS_SPECIAL    = 4'd11,
    CLS_DUAL_ADDR  = 4'd12,
    CLS_RSVD       = 4'd15
  } cmd_class_e;

  typedef enum logic [1:0] {
    BST_NONE   = 2'd0,
    BST_LINEAR = 2'd1,
    BST_WRAP   = 2'd2,
    BST_RSVD   = 2'd3
  } burst_e;
endpackage

// File: rtl/pad_cmd_decode.sv
module pad_cmd_decode
  import pad_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic [1:0] ord,
  output cmd_class_e cls,
  output burst_e     burst,
  output logic       is_mem
);
  always_comb begin
    unique case (cmd)
      4'b0000: cls = CLS_INT_ACK;
      4'b0001: cls = CLS_SPECIAL;
      4'b0010: cls = CLS_IO_RD;
      4'b0011: cls = CLS_IO_WR;
      4'b0110: cls = CLS_MEM_RD;
      4'b0111: cls = CLS_MEM_WR;
      4'b1010: cls = CLS_CFG_RD;
      4'b1011: cls = CLS_CFG_WR;
      4'b1100: cls = CLS_MEM_RDMULT;
      4'b1101: cls = CLS_DUAL_ADDR;
      4'b1110: cls = CLS_MEM_RDLINE;
      4'b1111: cls = CLS_MEM_WRINV;
      default: cls = CLS_RSVD;
    endcase
  end

  always_comb begin
    is_mem = (cls == CLS_MEM_RD) || (cls == CLS_MEM_WR) ||
             (cls == CLS_MEM_RDMULT) || (cls == CLS_MEM_RDLINE) ||
             (cls == CLS_MEM_WRINV);
    if (!is_mem)          burst = BST_NONE;
    else if (ord == 2'b00) burst = BST_LINEAR;
    else if (ord == 2'b10) burst = BST_WRAP;
    else                   burst = BST_RSVD;
  end
endmodule

// File: rtl/pad_window_match.sv
module pad_window_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  always_comb hit = ((addr & mask) == (base & mask));
endmodule

// File: rtl/pad_parity.sv
module pad_parity #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cmd,
  input  logic          par,
  output logic          err
);
  always_comb err = ^{addr, cmd, par};
endmodule

// File: rtl/pci_addr_decode.sv
module pci_addr_decode
  import pad_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 4,
  parameter int SUB_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic [AW-1:0] ad,
  input  logic [CW-1:0] cbe,
  input  logic          par,
  input  logic [AW-1:0] win_base,
  input  logic [AW-1:0] win_mask,
  input  logic          sub_mode,
  input  logic          other_claim,
  output logic          claim_o,
  output logic [3:0]    cls_o,
  output logic [1:0]    burst_o,
  output logic          disc_o,
  output logic          perr_o
);
  localparam int SCW = $clog2(SUB_DLY + 1);

  // reset synchronizer: assert async, release on clock
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  // state
  logic           frame_q;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  cmd_q;
  logic           stg1_q;
  logic [SCW-1:0] sub_cnt_q;
  logic           sub_disc_q;

  logic           start;
  cmd_class_e     dec_cls;
  burst_e         dec_burst;
  logic           dec_mem, win_hit, par_err;

  // next-state
  logic           stg1_d, claim_d, disc_d, perr_d, sub_disc_d;
  logic [SCW-1:0] sub_cnt_d;
  logic [3:0]     cls_d;
  logic [1:0]     burst_d;
  logic           upd_cls;

  assign start = frame_q & ~frame_n;

  pad_cmd_decode u_cmd (
    .cmd(cmd_q), .ord(addr_q[1:0]), .cls(dec_cls), .burst(dec_burst), .is_mem(dec_mem)
  );
  pad_window_match #(.AW(AW)) u_win (
    .addr(addr_q), .base(win_base), .mask(win_mask), .hit(win_hit)
  );
  pad_parity #(.AW(AW), .CW(CW)) u_par (
    .addr(addr_q), .cmd(cmd_q), .par(par), .err(par_err)
  );

  always_comb begin
    stg1_d     = start;
    claim_d    = 1'b0;
    disc_d     = 1'b0;
    perr_d     = 1'b0;
    upd_cls    = 1'b0;
    cls_d      = cls_o;
    burst_d    = burst_o;
    sub_cnt_d  = sub_cnt_q;
    sub_disc_d = sub_disc_q;
    if (start) begin
      sub_cnt_d = '0;
    end else if (stg1_q) begin
      upd_cls    = 1'b1;
      cls_d      = dec_cls;
      burst_d    = dec_burst;
      perr_d     = par_err;
      sub_disc_d = (dec_burst == BST_RSVD);
      if (!sub_mode) begin
        claim_d = dec_mem & win_hit;
        disc_d  = dec_mem & win_hit & (dec_burst == BST_RSVD);
      end else if (dec_mem && !other_claim) begin
        sub_cnt_d = SCW'(1);
      end
    end else if (sub_cnt_q != '0) begin
      if (other_claim) begin
        sub_cnt_d = '0;
      end else if (sub_cnt_q == SCW'(SUB_DLY - 1)) begin
        sub_cnt_d = '0;
        claim_d   = 1'b1;
        disc_d    = sub_disc_q;
      end else begin
        sub_cnt_d = sub_cnt_q + SCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      frame_q    <= 1'b1;
      stg1_q     <= 1'b0;
      sub_cnt_q  <= '0;
      sub_disc_q <= 1'b0;
      claim_o    <= 1'b0;
      disc_o     <= 1'b0;
      perr_o     <= 1'b0;
      cls_o      <= CLS_NONE;
      burst_o    <= BST_NONE;
    end else begin
      frame_q    <= frame_n;
      stg1_q     <= stg1_d;
      sub_cnt_q  <= sub_cnt_d;
      sub_disc_q <= sub_disc_d;
      claim_o    <= claim_d;
      disc_o     <= disc_d;
      perr_o     <= perr_d;
      if (upd_cls) begin
        cls_o   <= cls_d;
        burst_o <= burst_d;
      end
    end
  end

  // address capture with explicit enable
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (start) begin
      addr_q <= ad;
      cmd_q  <= cbe;
    end
  end

  // R6
  rsvd_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    claim_o |-> (cls_o != CLS_RSVD));
  // R3
  disc_with_claim_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    disc_o |-> (claim_o && burst_o == BST_RSVD));
  // R4
  nonmem_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cls_o >= 4'd6) |-> (burst_o == BST_NONE && !disc_o));
  // R5
  claim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    claim_o |=> !claim_o);
  // R7
  perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    perr_o |=> !perr_o);
  // R9
  sub_cancel_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sub_mode && other_claim && !stg1_q && !start) |=> !claim_o);
endmodule

// File: tb/pci_addr_decode_tb_top.sv
module pci_addr_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        par = 1'b0;
  logic [31:0] win_base = 32'h4000_0000;
  logic [31:0] win_mask = 32'hF000_0000;
  logic        sub_mode = 1'b0;
  logic        other_claim = 1'b0;
  logic        claim_o, disc_o, perr_o;
  logic [3:0]  cls_o;
  logic [1:0]  burst_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pci_addr_decode dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe(cbe), .par(par),
    .win_base(win_base), .win_mask(win_mask), .sub_mode(sub_mode),
    .other_claim(other_claim), .claim_o(claim_o), .cls_o(cls_o),
    .burst_o(burst_o), .disc_o(disc_o), .perr_o(perr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one address phase; returns just after edge A+1
  task automatic addr_phase(input logic [31:0] a, input logic [3:0] c, input logic bad_par);
    @(negedge clk);
    frame_n = 1'b0; ad = a; cbe = c;
    @(negedge clk);
    frame_n = 1'b1; par = (^a) ^ (^c) ^ bad_par; ad = 32'hDEAD_BEEF; cbe = 4'h0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 claim", claim_o, 0); chk("R10 disc", disc_o, 0);
    chk("R10 perr", perr_o, 0);   chk("R10 cls", cls_o, 0);
    chk("R10 burst", burst_o, 0);
  endtask

  task automatic t_linear();
    addr_phase(32'h4000_1000, 4'b0110, 0);
    chk("R5 claim hit", claim_o, 1); chk("R1 cls memrd", cls_o, 1);
    chk("R2 linear", burst_o, 1);    chk("R3 no disc", disc_o, 0);
    chk("R7 no perr", perr_o, 0);
    @(negedge clk); chk("R5 pulse", claim_o, 0); chk("R1 hold", cls_o, 1);
    idle(2);
  endtask

  task automatic t_wrap();
    addr_phase(32'h4ABC_0002, 4'b0111, 0);
    chk("R2 wrap", burst_o, 2); chk("R1 cls memwr", cls_o, 2);
    chk("R5 claim", claim_o, 1); chk("R3 no disc wrap", disc_o, 0);
    idle(2);
  endtask

  task automatic t_rsvd_order(input logic [1:0] lo);
    addr_phase(32'h4000_0000 | 32'(lo), 4'b1100, 0);
    chk("R3 burst rsvd", burst_o, 3); chk("R3 disc", disc_o, 1);
    chk("R3 claim", claim_o, 1);      chk("R1 cls rdmult", cls_o, 3);
    idle(2);
  endtask

  task automatic t_miss();
    addr_phase(32'h5000_0000, 4'b0110, 0);
    chk("R5 miss no claim", claim_o, 0); chk("R5 miss no disc", disc_o, 0);
    idle(2);
  endtask

  task automatic t_rsvd_cmd(input logic [3:0] c);
    addr_phase(32'h4000_0001, c, 0);
    chk("R6 rsvd no claim", claim_o, 0); chk("R1 cls rsvd", cls_o, 15);
    chk("R6 rsvd no disc", disc_o, 0);
    idle(2);
  endtask

  task automatic t_line_cmds();
    addr_phase(32'h4000_0010, 4'b1110, 0);
    chk("R1 cls rdline", cls_o, 4); chk("R5 rdline claim", claim_o, 1);
    idle(2);
    addr_phase(32'h4000_0020, 4'b1111, 0);
    chk("R1 cls wrinv", cls_o, 5); chk("R5 wrinv claim", claim_o, 1);
    idle(2);
  endtask

  task automatic t_io_cfg();
    addr_phase(32'h4000_0001, 4'b0010, 0);
    chk("R1 cls ioread", cls_o, 6); chk("R4 io burst none", burst_o, 0);
    chk("R4 io no disc", disc_o, 0); chk("R4 io no claim", claim_o, 0);
    idle(2);
    addr_phase(32'h4000_0003, 4'b1011, 0);
    chk("R1 cls cfgwr", cls_o, 9); chk("R4 cfg burst none", burst_o, 0);
    idle(2);
  endtask

  task automatic t_parity();
    addr_phase(32'h4000_0100, 4'b0110, 1);
    chk("R7 perr", perr_o, 1);
    @(negedge clk); chk("R7 perr pulse", perr_o, 0);
    idle(1);
    // flip only ad[0] after computing parity for the original address
    @(negedge clk);
    frame_n = 1'b0; ad = 32'h4000_0101; cbe = 4'b0110;
    @(negedge clk);
    frame_n = 1'b1; par = (^32'h4000_0100) ^ (^4'b0110); ad = '0; cbe = '0;
    @(negedge clk);
    chk("R7 ad0 in parity", perr_o, 1);
    idle(2);
  endtask

  task automatic t_sub_ok();
    sub_mode = 1'b1; other_claim = 1'b0;
    addr_phase(32'h9000_0000, 4'b0110, 0);
    chk("R8 no early claim A1", claim_o, 0);
    @(negedge clk); chk("R8 no early claim A2", claim_o, 0);
    @(negedge clk); chk("R8 claim A3", claim_o, 1);
    @(negedge clk); chk("R8 pulse", claim_o, 0);
    idle(2);
    sub_mode = 1'b0;
  endtask

  task automatic t_sub_cancel();
    sub_mode = 1'b1; other_claim = 1'b0;
    addr_phase(32'h9000_0000, 4'b0111, 0);
    other_claim = 1'b1;
    @(negedge clk); other_claim = 1'b0;
    @(negedge clk); chk("R9 cancelled", claim_o, 0);
    @(negedge clk); chk("R9 stays off", claim_o, 0);
    idle(2);
    sub_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_linear();
    t_wrap();
    t_rsvd_order(2'b01);
    t_rsvd_order(2'b11);
    t_miss();
    t_rsvd_cmd(4'b0100);
    t_rsvd_cmd(4'b1001);
    t_line_cmds();
    t_io_cfg();
    t_parity();
    t_sub_ok();
    t_sub_cancel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule